// File: doc/BRIEF.md
# Single-Shot Current ADC Request Controller

This block is the control and sequencing front end of a 16-bit current-measuring ADC that performs one conversion per software request. Software reaches it over a byte-wide register bus with a combinational read path. Through this bus it loads the conversion settings: a mode word, an input channel number, a clock and decimation word, a settling delay and a fast-averaging word. These settings are driven continuously to the converter.

Writing the request bit starts the sequence. The block first marks the request as pending and clears end-of-conversion. It then counts out the programmed settling delay, in steps of `SETTLE_UNIT` clock cycles, and pulses the start line of the converter. It waits for the converter's done strobe and captures the 16-bit sample into a low and a high result byte. Finally it clears pending and raises end-of-conversion, which stays set until the next accepted request. The converter itself sits outside the block behind a start/done/sample port.

Top module: `cadc_req_ctrl`

## Requirements
- R1: After reset, every readable register reads 0x00, `eoc_o` and `conv_start_o` are low, and all converter setting outputs are zero.
- R2: Register offsets are 0x40 mode (writable bits 0, 1, 2 and 4, others read 0), 0x48 channel select, 0x50 digital parameter (bits 3:0 kept), 0x51 settling delay (8 bits) and 0x5A averaging (8 bits). The request offset 0x52 and unmapped offsets read 0x00.
- R3: The channel number is held in bits 7:3 of 0x48 and reads back with bits 2:0 zero. In 0x50, bits 1:0 are clock select and bits 3:2 are decimation. These fields drive `conv_chan_o`, `conv_clk_sel_o` and `conv_dec_o`.
- R4: When the block is idle, a write to 0x52 with bit 7 set is accepted. In the following cycle, status at 0x08 reads bit 1 (pending) = 1 and bit 0 (end of conversion) = 0. A write to 0x52 with bit 7 clear has no effect. Pending and end of conversion are never both set.
- R5: `conv_start_o` is high for exactly one cycle. It rises exactly settle×`SETTLE_UNIT`+1 clock edges after the edge that accepts the request; a delay of 0 gives 1 cycle.
- R6: In the cycle after `conv_done_i` is seen while the block waits for the converter, the sample appears with bits 7:0 at 0x60 and bits 15:8 at 0x61. In that same cycle status reads 0x01 and `eoc_o` is high.
- R7: End of conversion stays set until a request is accepted.
- R8: A request written while one is pending is ignored: there is no extra start pulse and no restart of the delay, and the result comes from the first conversion.
- R9: The result bytes change only when a sample is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_re_i | input | 1 | Read strobe; read data is valid while high |
| bus_rdata_o | output | 8 | Read data, zero when no read |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| conv_done_i | input | 1 | Converter done strobe |
| conv_sample_i | input | 16 | Converter sample, valid with done |
| conv_mode_o | output | 8 | Mode setting to the converter |
| conv_chan_o | output | 5 | Selected channel number |
| conv_clk_sel_o | output | 2 | Converter clock select |
| conv_dec_o | output | 2 | Decimation ratio select |
| conv_settle_o | output | 8 | Programmed settling delay |
| conv_avg_o | output | 8 | Fast-averaging setup |
| eoc_o | output | 1 | End of conversion, mirrors status bit 0 |

## Verification
A table of six settings is walked in turn. Its entries use channel numbers 0, 1, 7, 12, 20 and 31, every clock and decimation code, and settling delays of 0, 1, 2, 3, 10 and 255. The walk also uses samples with opposite-valued bytes, so a swapped byte order, a wrong field shift or an off-by-one delay count each show up as a distinct mismatch. A long converter latency keeps a conversion in flight while further requests arrive, which separates "ignored" from "restarted". Writes to the request register with bit 7 clear, and waits after completion, show whether end of conversion and the result bytes hold.

// File: rtl/cadc_pkg.sv
package cadc_pkg;
  localparam logic [7:0] OFS_STATUS = 8'h08;
  localparam logic [7:0] OFS_MODE   = 8'h40;
  localparam logic [7:0] OFS_CHSEL  = 8'h48;
  localparam logic [7:0] OFS_DIG    = 8'h50;
  localparam logic [7:0] OFS_SETTLE = 8'h51;
  localparam logic [7:0] OFS_REQ    = 8'h52;
  localparam logic [7:0] OFS_AVG    = 8'h5A;
  localparam logic [7:0] OFS_RES    = 8'h60;

  localparam logic [7:0] MODE_MASK  = 8'h17;
  localparam logic [7:0] CHSEL_MASK = 8'hF8;
  localparam logic [7:0] DIG_MASK   = 8'h0F;
  localparam int unsigned REQ_BIT   = 7;
  localparam int unsigned CHAN_LSB  = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_START  = 2'd2,
    SEQ_WAIT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cadc_cfg_regs.sv
module cadc_cfg_regs
  import cadc_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] chsel_o,
  output logic [DW-1:0] dig_o,
  output logic [DW-1:0] settle_o,
  output logic [DW-1:0] avg_o,
  output logic [DW-1:0] rdata_o,
  output logic          hit_o
);
  logic [DW-1:0] mode_q, chsel_q, dig_q, settle_q, avg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      chsel_q  <= '0;
      dig_q    <= '0;
      settle_q <= '0;
      avg_q    <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        AW'(OFS_MODE):   mode_q   <= wdata_i & DW'(MODE_MASK);
        AW'(OFS_CHSEL):  chsel_q  <= wdata_i & DW'(CHSEL_MASK);
        AW'(OFS_DIG):    dig_q    <= wdata_i & DW'(DIG_MASK);
        AW'(OFS_SETTLE): settle_q <= wdata_i;
        AW'(OFS_AVG):    avg_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFS_MODE):   rdata_o = mode_q;
      AW'(OFS_CHSEL):  rdata_o = chsel_q;
      AW'(OFS_DIG):    rdata_o = dig_q;
      AW'(OFS_SETTLE): rdata_o = settle_q;
      AW'(OFS_AVG):    rdata_o = avg_q;
      default:         hit_o   = 1'b0;
    endcase
  end

  assign mode_o   = mode_q;
  assign chsel_o  = chsel_q;
  assign dig_o    = dig_q;
  assign settle_o = settle_q;
  assign avg_o    = avg_q;
endmodule

// File: rtl/cadc_seq.sv
module cadc_seq
  import cadc_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SETTLE_UNIT = 4,
  localparam int unsigned MAX_WAIT   = ((1 << DW) - 1) * SETTLE_UNIT,
  localparam int unsigned CNT_W      = $clog2(MAX_WAIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] settle_i,
  input  logic          conv_done_i,
  output logic          conv_start_o,
  output logic          latch_o,
  output logic          pending_o,
  output logic          eoc_o
);
  seq_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic pend_q, eoc_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(settle_i) * CNT_W'(SETTLE_UNIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (req_i) begin
          state_q <= SEQ_SETTLE;
          cnt_q   <= load_val;
          pend_q  <= 1'b1;
          eoc_q   <= 1'b0;
        end
        SEQ_SETTLE: begin
          if (cnt_q == '0) state_q <= SEQ_START;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        SEQ_START: state_q <= SEQ_WAIT;
        SEQ_WAIT: if (conv_done_i) begin
          state_q <= SEQ_IDLE;
          pend_q  <= 1'b0;
          eoc_q   <= 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign conv_start_o = (state_q == SEQ_START);
  assign latch_o      = (state_q == SEQ_WAIT) && conv_done_i;
  assign pending_o    = pend_q;
  assign eoc_o        = eoc_q;
endmodule

// File: rtl/cadc_result.sv
module cadc_result #(
  parameter int unsigned SW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned NB = SW / DW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   latch_i,
  input  logic [SW-1:0]          sample_i,
  output logic [NB-1:0][DW-1:0]  bytes_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q <= '0;
      else if (latch_i) byte_q <= sample_i[b*DW +: DW];
    end
    assign bytes_o[b] = byte_q;
  end
endmodule

// File: rtl/cadc_req_ctrl.sv
module cadc_req_ctrl
  import cadc_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned SW          = 16,
  parameter int unsigned SETTLE_UNIT = 4,
  localparam int unsigned NB         = SW / DW,
  localparam int unsigned CHAN_W     = DW - CHAN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [SW-1:0]     conv_sample_i,
  output logic [DW-1:0]     conv_mode_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic [1:0]        conv_clk_sel_o,
  output logic [1:0]        conv_dec_o,
  output logic [DW-1:0]     conv_settle_o,
  output logic [DW-1:0]     conv_avg_o,
  output logic              eoc_o
);
  logic [DW-1:0] mode_r, chsel_r, dig_r, settle_r, avg_r, cfg_rdata;
  logic cfg_hit, req_wr, latch, pend, eoc;
  logic [NB-1:0][DW-1:0] res_bytes;
  logic [SW-1:0] result_q;

  assign req_wr = bus_we_i && (bus_addr_i == AW'(OFS_REQ)) && bus_wdata_i[REQ_BIT];

  cadc_cfg_regs #(.AW(AW), .DW(DW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .mode_o   (mode_r),
    .chsel_o  (chsel_r),
    .dig_o    (dig_r),
    .settle_o (settle_r),
    .avg_o    (avg_r),
    .rdata_o  (cfg_rdata),
    .hit_o    (cfg_hit)
  );

  cadc_seq #(.DW(DW), .SETTLE_UNIT(SETTLE_UNIT)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_wr),
    .settle_i     (settle_r),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .latch_o      (latch),
    .pending_o    (pend),
    .eoc_o        (eoc)
  );

  cadc_result #(.SW(SW), .DW(DW)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .latch_i  (latch),
    .sample_i (conv_sample_i),
    .bytes_o  (res_bytes)
  );

  assign result_q = res_bytes;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      if (cfg_hit) bus_rdata_o = cfg_rdata;
      else if (bus_addr_i == AW'(OFS_STATUS)) bus_rdata_o = DW'({pend, eoc});
      for (int i = 0; i < NB; i++)
        if (bus_addr_i == AW'(OFS_RES) + AW'(i)) bus_rdata_o = res_bytes[i];
    end
  end

  assign conv_mode_o    = mode_r;
  assign conv_chan_o    = chsel_r[DW-1:CHAN_LSB];
  assign conv_clk_sel_o = dig_r[1:0];
  assign conv_dec_o     = dig_r[3:2];
  assign conv_settle_o  = settle_r;
  assign conv_avg_o     = avg_r;
  assign eoc_o          = eoc;
endmodule

// File: rtl/cadc_chk.sv
module cadc_chk #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SW          = 16,
  parameter int unsigned SETTLE_UNIT = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_wr_i,
  input logic          pending_i,
  input logic          eoc_i,
  input logic          start_i,
  input logic          latch_i,
  input logic [DW-1:0] settle_i,
  input logic [SW-1:0] result_i
);
  logic [31:0] win_q, exp_q;
  logic        started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= '0;
      exp_q     <= '0;
      started_q <= 1'b0;
    end else if (req_wr_i && !pending_i) begin
      win_q     <= '0;
      exp_q     <= 32'(settle_i) * 32'(SETTLE_UNIT) + 32'd1;
      started_q <= 1'b0;
    end else begin
      if (pending_i && !start_i && !started_q) win_q <= win_q + 32'd1;
      if (start_i) started_q <= 1'b1;
    end
  end

  AST_ACCEPT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && !pending_i) |=> (pending_i && !eoc_i)); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_i && eoc_i)); // R4
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i); // R5
  AST_SETTLE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (win_q == exp_q)); // R5
  AST_DONE_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (eoc_i && !pending_i)); // R6
  AST_EOC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_i && !req_wr_i) |=> eoc_i); // R7
  AST_SINGLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (pending_i && !started_q)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(result_i)); // R9
endmodule

bind cadc_req_ctrl cadc_chk #(.DW(DW), .SW(SW), .SETTLE_UNIT(SETTLE_UNIT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_wr_i  (req_wr),
  .pending_i (pend),
  .eoc_i     (eoc),
  .start_i   (conv_start_o),
  .latch_i   (latch),
  .settle_i  (settle_r),
  .result_i  (result_q)
);

// File: tb/sim_cadc_req_ctrl.sv
module sim_cadc_req_ctrl;
  localparam int unsigned UNIT = 4;
  localparam int unsigned NV = 6;
  // {chan[32:28], dec[27:26], clk[25:24], settle[23:16], sample[15:0]}
  localparam logic [32:0] VEC [NV] = '{
    {5'd0,  2'd0, 2'd0, 8'd0,   16'hA55A},
    {5'd1,  2'd1, 2'd2, 8'd1,   16'h00FF},
    {5'd7,  2'd2, 2'd1, 8'd3,   16'hFF00},
    {5'd31, 2'd3, 2'd3, 8'd10,  16'h8001},
    {5'd12, 2'd1, 2'd0, 8'd255, 16'h7FFE},
    {5'd20, 2'd0, 2'd3, 8'd2,   16'hFFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic we = 1'b0, re = 1'b0;
  logic start, done = 1'b0, eoc;
  logic [15:0] sample = '0, stub_sample = '0;
  logic [7:0] mode, settle, avg;
  logic [4:0] chan;
  logic [1:0] clk_sel, dec;
  int stub_lat = 2;
  int starts = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cadc_req_ctrl #(.SETTLE_UNIT(UNIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re),
    .bus_rdata_o(rdata),
    .conv_start_o(start), .conv_done_i(done), .conv_sample_i(sample),
    .conv_mode_o(mode), .conv_chan_o(chan), .conv_clk_sel_o(clk_sel),
    .conv_dec_o(dec), .conv_settle_o(settle), .conv_avg_o(avg), .eoc_o(eoc)
  );

  // converter stub
  initial forever begin
    @(negedge clk);
    if (start) begin
      starts++;
      repeat (stub_lat) @(negedge clk);
      done = 1'b1;
      sample = stub_sample;
      @(negedge clk);
      done = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; re = 1'b1;
    #2 d = rdata;
    re = 1'b0;
  endtask

  task automatic wait_eoc();
    int n = 0;
    while (!eoc && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cyc;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, d); chk("R1 status", d, 0);
    rd(8'h60, d); chk("R1 res lo", d, 0);
    rd(8'h61, d); chk("R1 res hi", d, 0);
    rd(8'h40, d); chk("R1 mode", d, 0);
    chk("R1 eoc_o", eoc, 0);
    chk("R1 start", start, 0);
    chk("R1 chan", chan, 0);

    // R2 register map and masks
    wr(8'h40, 8'hFF); rd(8'h40, d); chk("R2 mode mask", d, 8'h17);
    chk("R2 mode out", mode, 8'h17);
    wr(8'h5A, 8'hA5); rd(8'h5A, d); chk("R2 avg", d, 8'hA5);
    chk("R2 avg out", avg, 8'hA5);
    wr(8'h50, 8'hFF); rd(8'h50, d); chk("R2 dig mask", d, 8'h0F);
    rd(8'h33, d); chk("R2 unmapped", d, 0);
    rd(8'h52, d); chk("R2 req reads 0", d, 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      stub_lat = 2;
      stub_sample = v[15:0];
      wr(8'h48, {v[32:28], 3'b111});
      wr(8'h50, {4'hF, v[27:26], v[25:24]});
      wr(8'h51, v[23:16]);
      rd(8'h48, d); chk("R3 chsel readback", d, {v[32:28], 3'b000});
      chk("R3 conv_chan_o", chan, v[32:28]);
      chk("R3 conv_dec_o", dec, v[27:26]);
      chk("R3 conv_clk_sel_o", clk_sel, v[25:24]);
      rd(8'h51, d); chk("R2 settle readback", d, v[23:16]);
      s0 = starts;
      // request: write accepted at posedge, check next negedge
      @(negedge clk);
      addr = 8'h52; wdata = 8'h80; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      rd(8'h08, d); chk("R4 status pending", d, 8'h02);
      cyc = 0;
      while (!start && cyc < 5000) begin @(negedge clk); cyc++; end
      chk("R5 settle cycles", cyc, int'(v[23:16]) * UNIT + 1);
      @(negedge clk);
      chk("R5 start one cycle", start, 0);
      wait_eoc();
      rd(8'h08, d); chk("R6 status eoc", d, 8'h01);
      rd(8'h60, d); chk("R6 result lo", d, v[7:0]);
      rd(8'h61, d); chk("R6 result hi", d, v[15:8]);
      chk("R8 one start", starts - s0, 1);
    end

    // R7 eoc holds, write without bit 7 ignored, R9 result holds
    repeat (20) @(negedge clk);
    chk("R7 eoc holds", eoc, 1);
    s0 = starts;
    wr(8'h52, 8'h7F);
    repeat (30) @(negedge clk);
    rd(8'h08, d); chk("R4 no-bit7 ignored", d, 8'h01);
    chk("R4 no-bit7 no start", starts - s0, 0);
    rd(8'h60, d); chk("R9 lo held", d, 8'hFF);
    rd(8'h61, d); chk("R9 hi held", d, 8'hFF);

    // R8 request while busy
    wr(8'h51, 8'd2);
    stub_lat = 30;
    stub_sample = 16'h1357;
    s0 = starts;
    wr(8'h52, 8'h80);
    repeat (3) @(negedge clk);
    wr(8'h52, 8'h80);           // during settle
    cyc = 0;
    while (!start && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R8 start not delayed", cyc, 2 * int'(UNIT) + 1 - 5);
    repeat (5) @(negedge clk);
    wr(8'h52, 8'hFF);           // during conversion wait
    rd(8'h08, d); chk("R8 still pending", d, 8'h02);
    rd(8'h60, d); chk("R9 lo held during conv", d, 8'hFF);
    wait_eoc();
    repeat (60) @(negedge clk);
    chk("R8 single start", starts - s0, 1);
    rd(8'h08, d); chk("R8 status done", d, 8'h01);
    rd(8'h60, d); chk("R8 result lo", d, 8'h57);
    rd(8'h61, d); chk("R8 result hi", d, 8'h13);

    // R1 reset mid-use
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(8'h61, d); chk("R1 result after reset", d, 0);
    rd(8'h51, d); chk("R1 settle after reset", d, 0);
    chk("R1 eoc after reset", eoc, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule